// File: doc/BRIEF.md
# Neighbor Register Bank with FIFO Ring Mode

This block is a bank of context registers placed between two adjacent stages of a processing pipeline. Only the upstream stage can write it and only the downstream stage can read it, so the path between the two belongs to them alone and its latency never varies. The consumer sees the bank the way it sees its own general-purpose registers. A read is combinational from the index, so data written at one clock edge can be used in the very next cycle.

The same storage can be run in one of two ways, chosen by a level input. In register mode the producer writes and the consumer reads any entry by index. In ring mode the index inputs are ignored. Hardware put and get pointers turn the bank into a first-in first-out ring: each producer write is a push and each consumer read is a pop. The consumer sees the oldest entry on the read data output, and a count with full and empty flags reports how full the ring is. An overrun or underrun is dropped and recorded in a sticky error flag. Changing the mode empties the ring.

Top module: `nnr_ring_bank`

## Requirements
- R1: In register mode, a write stores wr_data_i at entry wr_idx_i. From the next cycle on, rd_data_o shows that value whenever rd_idx_i selects the entry.
- R2: When a write and a read address the same entry in the same cycle, rd_data_o in that cycle shows the value held before the write. Nothing is forwarded from the write port.
- R3: In ring mode, pushes fill entries starting at the put pointer and pops remove them starting at the get pointer. rd_data_o always shows the oldest entry held, so data leaves in the order it arrived. Both pointers wrap from entry 127 back to entry 0.
- R4: count_o gives the number of entries held in ring mode, from 0 to 128. full_o is 1 exactly when count_o is 128, and empty_o is 1 exactly when count_o is 0.
- R5: A push while full_o is 1 is dropped. The count and the stored data do not change, and err_o is set.
- R6: A pop while empty_o is 1 is dropped. The count does not change, and err_o is set.
- R7: Once set, err_o stays at 1 until reset.
- R8: In the first cycle in which ring_mode_i differs from the mode currently in force, the new mode takes effect. The pointers and the count are cleared, and any write or read request in that cycle is ignored.
- R9: After reset the bank is in register mode, with count_o 0, empty_o 1, full_o 0 and err_o 0. The stored data is kept across reset.
- R10: In ring mode, wr_idx_i and rd_idx_i have no effect. In register mode, count_o stays at 0 and empty_o stays at 1.
- R11: In ring mode, a push and a pop in the same cycle, while the ring is neither full nor empty, both take place, and count_o does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ring_mode_i | input | 1 | 0 selects register mode, 1 selects ring mode |
| wr_en_i | input | 1 | Producer write (push in ring mode) |
| wr_idx_i | input | 7 | Producer entry index (register mode only) |
| wr_data_i | input | 32 | Producer data |
| rd_en_i | input | 1 | Consumer pop request (ring mode only) |
| rd_idx_i | input | 7 | Consumer entry index (register mode only) |
| rd_data_o | output | 32 | Selected entry, or the oldest entry in ring mode |
| count_o | output | 8 | Entries held in ring mode |
| full_o | output | 1 | Ring holds 128 entries |
| empty_o | output | 1 | Ring holds no entries |
| err_o | output | 1 | Sticky overrun or underrun flag |

## Verification
The properties assume that ring_mode_i is driven synchronously and changes only between clock edges. They also assume that the flags can be judged against the mode currently in force, because the switch cycle itself is excluded from every push or pop property. The stimulus changes the mode only at the falling edge and holds it for many cycles. It deliberately sends pushes into a full ring and pops into an empty ring, so that the drop and error behaviour is exercised. The read data is compared only for entries the bench has written, because the storage is not cleared by reset.

// File: rtl/nnr_pkg.sv
package nnr_pkg;

  typedef enum logic {
    MODE_REG  = 1'b0,
    MODE_RING = 1'b1
  } nnr_mode_e;

  function automatic nnr_mode_e to_mode(input logic bit_i);
    return bit_i ? MODE_RING : MODE_REG;
  endfunction

endpackage

// File: rtl/nnr_rst_sync.sv
module nnr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/nnr_mode_track.sv
module nnr_mode_track
  import nnr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ring_mode_i,
  output nnr_mode_e mode_q,
  output logic      switch_o
);

  nnr_mode_e req_mode;
  nnr_mode_e mode_d;
  logic      mode_en;

  always_comb begin
    req_mode = to_mode(ring_mode_i);
    switch_o = (req_mode != mode_q);
    mode_en  = switch_o;
    mode_d   = req_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_REG;
    end else if (mode_en) begin
      mode_q <= mode_d;
    end
  end

endmodule

// File: rtl/nnr_ring_ctl.sv
module nnr_ring_ctl
  import nnr_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  nnr_mode_e     mode_q,
  input  logic          switch_i,
  input  logic          push_req_i,
  input  logic          pop_req_i,
  output logic [AW-1:0] put_ptr_o,
  output logic [AW-1:0] get_ptr_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          err_o,
  output logic          push_ok_o,
  output logic          pop_ok_o
);

  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CAP      = CW'(DEPTH);

  logic [AW-1:0] put_q, put_d;
  logic [AW-1:0] get_q, get_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          err_q, err_d;
  logic          ptr_en;
  logic          ring_active;
  logic          push_bad, pop_bad;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    ring_active = (mode_q == MODE_RING) && !switch_i;
    full_o      = (cnt_q == CAP);
    empty_o     = (cnt_q == '0);
    push_ok_o   = ring_active && push_req_i && !full_o;
    pop_ok_o    = ring_active && pop_req_i && !empty_o;
    push_bad    = ring_active && push_req_i && full_o;
    pop_bad     = ring_active && pop_req_i && empty_o;
  end

  always_comb begin
    put_d  = put_q;
    get_d  = get_q;
    cnt_d  = cnt_q;
    ptr_en = 1'b0;
    if (switch_i) begin
      put_d  = '0;
      get_d  = '0;
      cnt_d  = '0;
      ptr_en = 1'b1;
    end else if (push_ok_o || pop_ok_o) begin
      ptr_en = 1'b1;
      if (push_ok_o) begin
        put_d = bump(put_q);
      end
      if (pop_ok_o) begin
        get_d = bump(get_q);
      end
      case ({push_ok_o, pop_ok_o})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_comb begin
    err_d = err_q | push_bad | pop_bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      put_q <= '0;
      get_q <= '0;
      cnt_q <= '0;
    end else if (ptr_en) begin
      put_q <= put_d;
      get_q <= get_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (push_bad || pop_bad) begin
      err_q <= err_d;
    end
  end

  assign put_ptr_o = put_q;
  assign get_ptr_o = get_q;
  assign count_o   = cnt_q;
  assign err_o     = err_q;

endmodule

// File: rtl/nnr_store.sv
module nnr_store #(
  parameter int DEPTH = 128,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);

  logic [WIDTH-1:0] word_q [DEPTH];
  logic [DEPTH-1:0] sel;

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_comb begin
      sel[g] = we_i && (waddr_i == AW'(g));
    end

    always_ff @(posedge clk) begin
      if (sel[g]) begin
        word_q[g] <= wdata_i;
      end
    end
  end

  assign rdata_o = word_q[raddr_i];

endmodule

// File: rtl/nnr_ring_bank.sv
module nnr_ring_bank
  import nnr_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ring_mode_i,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_idx_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             rd_en_i,
  input  logic [AW-1:0]    rd_idx_i,
  output logic [WIDTH-1:0] rd_data_o,
  output logic [CW-1:0]    count_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             err_o
);

  logic          rst_sync_n;
  nnr_mode_e     mode_q;
  logic          switch_w;
  logic          in_ring;
  logic          push_req, pop_req;
  logic          push_ok, pop_ok;
  logic [AW-1:0] put_ptr, get_ptr;
  logic          st_we;
  logic [AW-1:0] st_waddr, st_raddr;

  nnr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  nnr_mode_track u_mode (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .ring_mode_i (ring_mode_i),
    .mode_q      (mode_q),
    .switch_o    (switch_w)
  );

  always_comb begin
    in_ring  = (mode_q == MODE_RING);
    push_req = in_ring && wr_en_i;
    pop_req  = in_ring && rd_en_i;
  end

  nnr_ring_ctl #(.DEPTH(DEPTH)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .mode_q     (mode_q),
    .switch_i   (switch_w),
    .push_req_i (push_req),
    .pop_req_i  (pop_req),
    .put_ptr_o  (put_ptr),
    .get_ptr_o  (get_ptr),
    .count_o    (count_o),
    .full_o     (full_o),
    .empty_o    (empty_o),
    .err_o      (err_o),
    .push_ok_o  (push_ok),
    .pop_ok_o   (pop_ok)
  );

  always_comb begin
    if (in_ring) begin
      st_we    = push_ok;
      st_waddr = put_ptr;
      st_raddr = get_ptr;
    end else begin
      st_we    = wr_en_i && !switch_w;
      st_waddr = wr_idx_i;
      st_raddr = rd_idx_i;
    end
  end

  nnr_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk     (clk),
    .we_i    (st_we),
    .waddr_i (st_waddr),
    .wdata_i (wr_data_i),
    .raddr_i (st_raddr),
    .rdata_o (rd_data_o)
  );

endmodule

// File: rtl/nnr_ring_bank_chk.sv
module nnr_ring_bank_chk #(
  parameter int DEPTH = 128,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode_ring,
  input logic          switch_i,
  input logic          wr_en_i,
  input logic          rd_en_i,
  input logic [CW-1:0] count_o,
  input logic          full_o,
  input logic          empty_o,
  input logic          err_o
);

  logic active;
  assign active = mode_ring && !switch_i;

  p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    count_o <= CW'(DEPTH));

  p_push_grow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && wr_en_i && !rd_en_i && !full_o) |=> (count_o == $past(count_o) + 1'b1));

  p_full_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && wr_en_i && !rd_en_i && full_o) |=> (full_o && err_o));

  p_empty_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && rd_en_i && !wr_en_i && empty_o) |=> (empty_o && err_o));

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);

  p_switch_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    switch_i |=> (count_o == '0));

  p_reg_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_ring && !switch_i) |=> (empty_o && $stable(count_o)));

  p_both_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (active && wr_en_i && rd_en_i && !full_o && !empty_o) |=> $stable(count_o));

endmodule

bind nnr_ring_bank nnr_ring_bank_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .mode_ring (in_ring),
  .switch_i  (switch_w),
  .wr_en_i   (wr_en_i),
  .rd_en_i   (rd_en_i),
  .count_o   (count_o),
  .full_o    (full_o),
  .empty_o   (empty_o),
  .err_o     (err_o)
);

// File: tb/test_nnr_ring_bank.sv
module test_nnr_ring_bank;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 128;

  logic        clk;
  logic        rst_n;
  logic        ring_mode;
  logic        wr_en;
  logic [6:0]  wr_idx;
  logic [31:0] wr_data;
  logic        rd_en;
  logic [6:0]  rd_idx;
  logic [31:0] rd_data;
  logic [7:0]  count;
  logic        full, empty, err;

  int total = 0;
  int bad = 0;

  // behavioural reference state
  logic [31:0] m_mem [DEPTH];
  bit          m_val [DEPTH];
  bit          m_mode;
  int          m_put, m_get;
  bit          m_err;
  logic [31:0] m_q [$];

  nnr_ring_bank i_nnr_ring_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .ring_mode_i (ring_mode),
    .wr_en_i     (wr_en),
    .wr_idx_i    (wr_idx),
    .wr_data_i   (wr_data),
    .rd_en_i     (rd_en),
    .rd_idx_i    (rd_idx),
    .rd_data_o   (rd_data),
    .count_o     (count),
    .full_o      (full),
    .empty_o     (empty),
    .err_o       (err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic chk_status(input string tag);
    int n;
    n = m_q.size();
    chk(count == 8'(n), tag, "count", count, n);
    chk(full == (n == DEPTH), tag, "full", full, n == DEPTH);
    chk(empty == (n == 0), tag, "empty", empty, n == 0);
    chk(err == m_err, tag, "err", err, m_err);
  endtask

  // one clock: drive at falling edge, check, let edge pass, update model
  task automatic cyc(input bit md, input bit w, input int wi, input logic [31:0] wd,
                     input bit r, input int ri, input string tag);
    bit push_ok, pop_ok;
    ring_mode = md; wr_en = w; wr_idx = 7'(wi); wr_data = wd;
    rd_en = r; rd_idx = 7'(ri);
    #1;
    chk_status(tag);
    if (!m_mode && m_val[ri & 127])
      chk(rd_data === m_mem[ri & 127], tag, "rd_data(index)", rd_data, m_mem[ri & 127]);
    if (m_mode && m_q.size() > 0)
      chk(rd_data === m_q[0], tag, "rd_data(head)", rd_data, m_q[0]);
    @(posedge clk);
    if (md != m_mode) begin
      m_mode = md; m_put = 0; m_get = 0; m_q.delete();
    end else if (!md) begin
      if (w) begin m_mem[wi & 127] = wd; m_val[wi & 127] = 1'b1; end
    end else begin
      push_ok = w && (m_q.size() < DEPTH);
      pop_ok  = r && (m_q.size() > 0);
      if ((w && !push_ok) || (r && !pop_ok)) m_err = 1'b1;
      if (pop_ok) begin void'(m_q.pop_front()); m_get = (m_get + 1) % DEPTH; end
      if (push_ok) begin
        m_mem[m_put] = wd; m_val[m_put] = 1'b1; m_q.push_back(wd);
        m_put = (m_put + 1) % DEPTH;
      end
    end
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic do_reset();
    ring_mode = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    wr_idx = '0; rd_idx = '0; wr_data = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    m_mode = 1'b0; m_put = 0; m_get = 0; m_err = 1'b0; m_q.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) m_val[i] = 1'b0;
    do_reset();
    chk_status("R9");

    // R1: register writes, read back by index
    for (int i = 0; i < 12; i++) cyc(0, 1, i * 9, 32'hA500_0000 + i, 0, 0, "R1");
    for (int i = 0; i < 12; i++) cyc(0, 0, 0, 0, 0, i * 9, "R1");
    cyc(0, 1, 127, 32'hFFFF_0001, 0, 127, "R1");
    cyc(0, 0, 0, 0, 0, 127, "R1");
    // R2: same-entry write and read in one cycle returns old data
    cyc(0, 1, 18, 32'h1234_5678, 1, 18, "R2");
    cyc(0, 0, 0, 0, 0, 18, "R2");
    // R10: pop request in register mode changes nothing
    cyc(0, 0, 0, 0, 1, 9, "R10");

    // R8: switch to ring with requests present, ignored
    cyc(1, 1, 3, 32'hDEAD_0000, 1, 3, "R8");
    cyc(1, 0, 0, 0, 0, 0, "R8");

    // R3/R10: push with random indices, pop in order
    for (int i = 0; i < 5; i++) cyc(1, 1, 100 - i, 32'hB000_0000 + i, 0, 77, "R3");
    for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0, 1, i * 31, "R3");

    // R11: simultaneous push and pop
    cyc(1, 1, 0, 32'hC000_0000, 0, 0, "R11");
    for (int i = 1; i < 6; i++) cyc(1, 1, i, 32'hC000_0000 + i, 1, i, "R11");
    cyc(1, 0, 0, 0, 1, 0, "R11");

    // R4: fill the ring, pointers wrap
    for (int i = 0; i < DEPTH; i++) cyc(1, 1, i, 32'hD000_0000 + i, 0, 0, "R4");
    // R5: push when full is dropped
    cyc(1, 1, 0, 32'hEEEE_EEEE, 0, 0, "R5");
    cyc(1, 0, 0, 0, 0, 0, "R5");
    // R5/R11 edge: push and pop when full -> pop only
    cyc(1, 1, 0, 32'hEEEE_0002, 1, 0, "R5");
    // R3: drain across the wrap
    for (int i = 0; i < DEPTH - 1; i++) cyc(1, 0, 0, 0, 1, 0, "R3");
    // R7: error stays set
    for (int i = 0; i < 4; i++) cyc(1, 0, 0, 0, 0, 0, "R7");

    // R9: reset clears error, keeps storage
    do_reset();
    chk_status("R9");
    cyc(0, 0, 0, 0, 0, 18, "R9");

    // R6: pop when empty
    cyc(1, 0, 0, 0, 0, 0, "R8");
    cyc(1, 0, 0, 0, 1, 0, "R6");
    cyc(1, 0, 0, 0, 0, 0, "R6");
    cyc(1, 1, 0, 32'hF000_0001, 0, 0, "R6");
    cyc(1, 1, 0, 32'hF000_0002, 0, 0, "R6");

    // R8: switch back with entries held, count cleared; index reads see ring data
    cyc(0, 1, 0, 32'h0BAD_0BAD, 0, 0, "R8");
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, i, "R8");
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 0, 120 + i, "R10");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule